// File: doc/BRIEF.md
# Interlaced Read-Port Capture Scan Chain

This block sits behind the two read ports of a 32-word register file under test. It records the word on each read port into a serial scan chain. The same chain can then be shifted, which sends the recorded words out one bit per clock and loads a new pattern in from the other end. The chain is built from segments that are joined end to end. Each segment covers one slice of both read ports and keeps two control bits at its low end.

While `scan_en` is low, each segment keeps its two control bits and loads its data bits from the read ports on every clock. While `scan_en` is high, every bit of the chain moves one place toward the serial output. That shift is the only way to read the captured words and the only way to set the control bits. For each segment, one control bit picks which port's slice goes to the downstream comparator on `cmp_data`. The other control bit goes straight out on `cmp_mode`, where the comparator uses it to choose between fixed-value and LFSR checking.

Top module: `rfcap_chain`

## Requirements
- R1: While `rst_n` is low, every chain bit is 0. `scan_out`, `cmp_data` and `cmp_mode` therefore read 0, and the chain still holds all zeros once reset has been released.
- R2: Chain layout, with global index j = 34*k + b for segment k (0 or 1) and local bit b. b=0 is the port-select bit, b=1 is the mode bit, b=2+2i holds `rd_a[16k+i]` and b=3+2i holds `rd_b[16k+i]`, for i from 0 to 15.
- R3: On every clock with `scan_en` high, each bit moves from index j+1 to index j. `scan_in` enters at index 67. `scan_out` always shows index 0, so 68 shifts read out the whole chain lowest index first.
- R4: On every clock with `scan_en` low, every data bit loads the read-port bit that R2 assigns to it.
- R5: On a clock with `scan_en` low, the two control bits of every segment keep their values.
- R6: `cmp_data[16k+15:16k]` shows segment k's captured port A slice when that segment's select bit is 0, and its port B slice when the bit is 1. It follows the chain state with no extra register.
- R7: `cmp_mode[k]` equals the mode bit of segment k.
- R8: A single shift pass reads out the previous chain contents and leaves the newly shifted pattern in place, control bits included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_en | input | 1 | 1: shift the chain; 0: capture from the read ports |
| scan_in | input | 1 | Serial data into chain index 67 |
| rd_a | input | 32 | Read port A data |
| rd_b | input | 32 | Read port B data |
| scan_out | output | 1 | Chain index 0 |
| cmp_data | output | 32 | Selected port slice per segment, to the comparator |
| cmp_mode | output | 2 | Mode bit per segment, to the comparator |

## Verification
The bench runs every one of the 16 combinations of select and mode bits across both segments, each with several data patterns. Each pass shifts a pattern in, then captures twice, then reads back on the next shift. A design that swapped the A/B interlace, or reversed the order inside a segment, would return permuted words on readback. A design that let the control bits capture during load mode would flip the port choice on `cmp_data`. A broken link between the two segments would corrupt the upper half of every readback. If `cmp_data` lagged by a register, the second capture would still show the first capture's values.

// File: rtl/rfcap_pkg.sv
package rfcap_pkg;
  localparam int unsigned CTRL_BITS = 2;
  localparam int unsigned SEL_POS   = 0;
  localparam int unsigned MODE_POS  = 1;

  typedef enum logic {
    OP_CAPTURE = 1'b0,
    OP_SHIFT   = 1'b1
  } cap_op_e;
endpackage

// File: rtl/rfcap_rst_sync.sv
module rfcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/rfcap_segment.sv
module rfcap_segment
  import rfcap_pkg::*;
#(
  parameter int unsigned SEG_BITS = 16,
  localparam int unsigned SEG_LEN = CTRL_BITS + 2 * SEG_BITS
) (
  input  logic                clk,
  input  logic                rst_core_n,
  input  cap_op_e             op,
  input  logic                ser_in,
  input  logic [SEG_BITS-1:0] slice_a,
  input  logic [SEG_BITS-1:0] slice_b,
  output logic [SEG_LEN-1:0]  state_o,
  output logic [SEG_BITS-1:0] cap_a,
  output logic [SEG_BITS-1:0] cap_b,
  output logic                port_sel,
  output logic                grp_mode
);
  logic [SEG_LEN-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (op == OP_SHIFT) begin
      state_d = {ser_in, state_q[SEG_LEN-1:1]};
    end else begin
      for (int i = 0; i < int'(SEG_BITS); i++) begin
        state_d[CTRL_BITS + 2*i]     = slice_a[i];
        state_d[CTRL_BITS + 2*i + 1] = slice_b[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= '0;
    else             state_q <= state_d;
  end

  always_comb begin
    for (int i = 0; i < int'(SEG_BITS); i++) begin
      cap_a[i] = state_q[CTRL_BITS + 2*i];
      cap_b[i] = state_q[CTRL_BITS + 2*i + 1];
    end
  end

  assign port_sel = state_q[SEL_POS];
  assign grp_mode = state_q[MODE_POS];
  assign state_o  = state_q;
endmodule

// File: rtl/rfcap_portmux.sv
module rfcap_portmux #(
  parameter int unsigned W = 16
) (
  input  logic         sel_b,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_y
);
  always_comb begin
    if (sel_b) out_y = in_b;
    else       out_y = in_a;
  end
endmodule

// File: rtl/rfcap_chain.sv
module rfcap_chain
  import rfcap_pkg::*;
#(
  parameter int unsigned SEG_BITS = 16,
  parameter int unsigned NUM_SEG  = 2,
  localparam int unsigned PORT_W    = SEG_BITS * NUM_SEG,
  localparam int unsigned SEG_LEN   = CTRL_BITS + 2 * SEG_BITS,
  localparam int unsigned CHAIN_LEN = SEG_LEN * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_in,
  input  logic [PORT_W-1:0] rd_a,
  input  logic [PORT_W-1:0] rd_b,
  output logic              scan_out,
  output logic [PORT_W-1:0] cmp_data,
  output logic [NUM_SEG-1:0] cmp_mode
);
  logic              rst_core_n;
  cap_op_e           op;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [PORT_W-1:0] cap_a_w, cap_b_w;
  logic [NUM_SEG-1:0] sel_w;

  assign op = scan_en ? OP_SHIFT : OP_CAPTURE;

  rfcap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  for (genvar k = 0; k < int'(NUM_SEG); k++) begin : g_seg
    logic ser_in_w;
    if (k == int'(NUM_SEG) - 1) begin : g_head
      assign ser_in_w = scan_in;
    end else begin : g_link
      assign ser_in_w = chain_q[SEG_LEN*(k+1)];
    end

    rfcap_segment #(.SEG_BITS(SEG_BITS)) u_seg (
      .clk        (clk),
      .rst_core_n (rst_core_n),
      .op         (op),
      .ser_in     (ser_in_w),
      .slice_a    (rd_a[SEG_BITS*k +: SEG_BITS]),
      .slice_b    (rd_b[SEG_BITS*k +: SEG_BITS]),
      .state_o    (chain_q[SEG_LEN*k +: SEG_LEN]),
      .cap_a      (cap_a_w[SEG_BITS*k +: SEG_BITS]),
      .cap_b      (cap_b_w[SEG_BITS*k +: SEG_BITS]),
      .port_sel   (sel_w[k]),
      .grp_mode   (cmp_mode[k])
    );

    rfcap_portmux #(.W(SEG_BITS)) u_mux (
      .sel_b (sel_w[k]),
      .in_a  (cap_a_w[SEG_BITS*k +: SEG_BITS]),
      .in_b  (cap_b_w[SEG_BITS*k +: SEG_BITS]),
      .out_y (cmp_data[SEG_BITS*k +: SEG_BITS])
    );
  end

  assign scan_out = chain_q[0];
endmodule

// File: rtl/rfcap_chain_chk.sv
module rfcap_chain_chk #(
  parameter int unsigned SEG_BITS = 16,
  parameter int unsigned NUM_SEG  = 2,
  localparam int unsigned PORT_W    = SEG_BITS * NUM_SEG,
  localparam int unsigned SEG_LEN   = 2 + 2 * SEG_BITS,
  localparam int unsigned CHAIN_LEN = SEG_LEN * NUM_SEG
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic                 scan_en,
  input logic                 scan_in,
  input logic                 scan_out,
  input logic [PORT_W-1:0]    rd_a,
  input logic [PORT_W-1:0]    rd_b,
  input logic [CHAIN_LEN-1:0] chain_q,
  input logic [PORT_W-1:0]    cap_a_w,
  input logic [PORT_W-1:0]    cap_b_w
);
  logic [2*NUM_SEG-1:0] ctrl_v;

  always_comb begin
    for (int k = 0; k < int'(NUM_SEG); k++) begin
      ctrl_v[2*k]   = chain_q[SEG_LEN*k];
      ctrl_v[2*k+1] = chain_q[SEG_LEN*k + 1];
    end
  end

  // R3: serial input lands at the top and the rest moves down by one
  a_r3_shift_move: assert property (@(posedge clk) disable iff (!rst_core_n)
    scan_en |=> (chain_q == {$past(scan_in), $past(chain_q[CHAIN_LEN-1:1])}));

  // R3: serial output presents the bit that sat one place up
  a_r3_shift_out: assert property (@(posedge clk) disable iff (!rst_core_n)
    scan_en |=> (scan_out == $past(chain_q[1])));

  // R4: capture loads both read ports
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_core_n)
    !scan_en |=> (cap_a_w == $past(rd_a)) && (cap_b_w == $past(rd_b)));

  // R5: control bits frozen while capturing
  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !scan_en |=> $stable(ctrl_v));
endmodule

bind rfcap_chain rfcap_chain_chk #(.SEG_BITS(SEG_BITS), .NUM_SEG(NUM_SEG)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .scan_en    (scan_en),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .rd_a       (rd_a),
  .rd_b       (rd_b),
  .chain_q    (chain_q),
  .cap_a_w    (cap_a_w),
  .cap_b_w    (cap_b_w)
);

// File: tb/sim_rfcap_chain.sv
module sim_rfcap_chain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en;
  logic        scan_in;
  logic [31:0] rd_a, rd_b;
  logic        scan_out;
  logic [31:0] cmp_data;
  logic [1:0]  cmp_mode;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  rfcap_chain u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .scan_out (scan_out),
    .cmp_data (cmp_data),
    .cmp_mode (cmp_mode)
  );

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 layout computed from the requirement
  function automatic logic [67:0] layout(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [67:0] v;
    for (int k = 0; k < 2; k++) begin
      v[34*k]     = c[2*k];
      v[34*k + 1] = c[2*k+1];
      for (int i = 0; i < 16; i++) begin
        v[34*k + 2 + 2*i] = a[16*k + i];
        v[34*k + 3 + 2*i] = b[16*k + i];
      end
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_cmp(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    return {c[2] ? b[31:16] : a[31:16], c[0] ? b[15:0] : a[15:0]};
  endfunction

  // Shift v in (index 0 first); returns the bits seen on scan_out
  task automatic shift_vec(input logic [67:0] v, output logic [67:0] got);
    for (int t = 0; t < 68; t++) begin
      got[t]  = scan_out;
      scan_en = 1'b1;
      scan_in = v[t];
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check_readback(input logic [67:0] got, input logic [67:0] exp);
    logic [31:0] ga, gb, ea, eb;
    logic [3:0]  gc, ec;
    for (int k = 0; k < 2; k++) begin
      gc[2*k] = got[34*k];  gc[2*k+1] = got[34*k+1];
      ec[2*k] = exp[34*k];  ec[2*k+1] = exp[34*k+1];
      for (int i = 0; i < 16; i++) begin
        ga[16*k+i] = got[34*k+2+2*i]; gb[16*k+i] = got[34*k+3+2*i];
        ea[16*k+i] = exp[34*k+2+2*i]; eb[16*k+i] = exp[34*k+3+2*i];
      end
    end
    check("R2 R3 readback port A word", {36'd0, ga}, {36'd0, ea});
    check("R2 R3 readback port B word", {36'd0, gb}, {36'd0, eb});
    check("R8 readback control bits", {64'd0, gc}, {64'd0, ec});
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [67:0] expect_chain, got, v;
    logic [31:0] a, b, a2, b2;
    rst_n = 1'b0; scan_en = 1'b1; scan_in = 1'b0; rd_a = '0; rd_b = '0;
    repeat (3) @(negedge clk);
    check("R1 reset scan_out", {67'd0, scan_out}, 68'd0);
    check("R1 reset cmp_data", {36'd0, cmp_data}, 68'd0);
    check("R1 reset cmp_mode", {66'd0, cmp_mode}, 68'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_chain = '0;

    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        a  = (32'(p + 1) * 32'h9E37_79B9) ^ {28'd0, 4'(c)};
        b  = {a[12:0], a[31:13]} ^ 32'hA5C3_0F96;
        a2 = ~b + 32'(c * 7 + p);
        b2 = a ^ 32'h3C5A_F00F;
        // pattern shifted in carries controls and its own data
        v = layout(4'(c), b2 ^ 32'h1234_5678, a2);
        shift_vec(v, got);
        check_readback(got, expect_chain);
        check("R7 cmp_mode after shift", {66'd0, cmp_mode}, {66'd0, 2'(c >> 1 & 1), 1'(c >> 1)} & 68'd0 | {66'd0, 1'(c >> 3), 1'(c >> 1)});
        check("R6 cmp_data after shift", {36'd0, cmp_data},
              {36'd0, exp_cmp(4'(c), b2 ^ 32'h1234_5678, a2)});
        // first capture
        scan_en = 1'b0; rd_a = a; rd_b = b;
        @(posedge clk); @(negedge clk);
        check("R4 R6 cmp_data capture 1", {36'd0, cmp_data}, {36'd0, exp_cmp(4'(c), a, b)});
        check("R5 cmp_mode held capture 1", {66'd0, cmp_mode}, {66'd0, 1'(c >> 3), 1'(c >> 1)});
        // second capture, new values must appear in the same cycle
        rd_a = a2; rd_b = b2;
        @(posedge clk); @(negedge clk);
        check("R4 R6 cmp_data capture 2", {36'd0, cmp_data}, {36'd0, exp_cmp(4'(c), a2, b2)});
        check("R5 R7 cmp_mode held capture 2", {66'd0, cmp_mode}, {66'd0, 1'(c >> 3), 1'(c >> 1)});
        expect_chain = layout(4'(c), a2, b2);
      end
    end
    shift_vec(68'd0, got);
    check_readback(got, expect_chain);
    check("R3 scan_out after flush", {67'd0, scan_out}, 68'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule